// File: doc/BRIEF.md
# Dual-Channel GPIO Register Block

This block is a general-purpose I/O peripheral that sits on a simple word-addressed register port. It offers one channel of pins, or two when the dual-channel parameter is set. Each channel holds two 32-bit registers. The output-value register sets the level that every pin of the channel presents. The direction register decides for each pin whether the output driver is on or off. A set direction bit makes the pin an input. Reading a channel's value register returns the pin levels after a two-flop synchroniser.

Software sets up a pin as an output in two writes. It first loads the output value, then clears the matching direction bit. After reset every pin is an input, unless the reset-value parameters say otherwise. A pin whose direction bit is set still keeps its stored output value, so clearing the bit later drives that value at once. The register offsets are byte addresses. Channel one uses offsets 0x0 (value) and 0x4 (direction). Channel two repeats this layout 8 bytes higher, at 0x8 and 0xC. The two lowest address bits are ignored.

Top module: `gpio_dual_regs`

## Requirements
- R1: After reset with default parameters, every direction bit is 1, every output value is 0, every output enable is 0, and the read data is 0.
- R2: Writing the direction register at offset 0x4 (channel one) or 0xC (channel two) sets each pin's output enable to the inverse of the written bit. A read of that offset returns the stored bits.
- R3: Writing the value register at offset 0x0 or 0x8 updates all output values of that channel together. Pins whose direction bit is 1 keep the new value on their output but do not enable it.
- R4: A read of a value register returns the pin inputs after two synchroniser flops. A read issued in the same cycle as a pin change returns the old level. Bits at and above the channel width read 0.
- R5: Channel two's registers at 0x8 and 0xC work independently of channel one. A write to one channel leaves the other channel's outputs and enables unchanged.
- R6: With the dual-channel parameter cleared, writes to 0x8 and 0xC have no effect on any output, reads from them return 0, and channel-two outputs and enables stay 0.
- R7: Offsets at 0x10 and above change no register, and reads from them return 0.
- R8: Read data is registered: it is valid in the cycle after the read strobe and holds its value while no read is strobed.
- R9: The reset values of each channel's value and direction registers follow their parameters.
- R10: A register write becomes visible on the outputs at the clock edge that samples the write strobe, and not before that edge. Write-data bits at and above the channel width are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ch1_pin_in | input | CH1_WIDTH | Channel one pin input levels |
| ch1_pin_out | output | CH1_WIDTH | Channel one pin output values |
| ch1_pin_oe | output | CH1_WIDTH | Channel one output enables, active high |
| ch2_pin_in | input | CH2_WIDTH | Channel two pin input levels |
| ch2_pin_out | output | CH2_WIDTH | Channel two pin output values |
| ch2_pin_oe | output | CH2_WIDTH | Channel two output enables, active high |

## Verification
The hardest case to reach from the ports is the read of a pin value during the synchroniser's latency. The bench therefore changes the pin inputs and issues a read strobe on the same clock. That read must return the old level. It then waits three cycles and reads again, and that read must return the new level. A second instance is built without channel two. It is used to show that writes to the missing channel's offsets have no effect, by checking every output and by reading back the remaining registers.

// File: rtl/gpio_dual_pkg.sv
// Shared definitions for the GPIO register block.
// Assumes 32-bit registers and byte addresses that are word aligned.
package gpio_dual_pkg;
    localparam int REG_W = 32;

    // Register selected by address bits [3:2]
    typedef enum logic [1:0] {
        SEL_VAL1 = 2'd0,
        SEL_DIR1 = 2'd1,
        SEL_VAL2 = 2'd2,
        SEL_DIR2 = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for a bus of independent pin inputs.
// Assumes each bit is sampled on its own; no bus coherency is implied.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] q1;
    logic [W-1:0] q2;

    // Shift the pin levels through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q1 <= '0;
            q2 <= '0;
        end else begin
            q1 <= din;
            q2 <= q1;
        end
    end

    assign dout = q2;

    p_stage1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> q1 == $past(din));
    p_stage2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> q2 == $past(q1));
endmodule

// File: rtl/gpio_channel.sv
// One GPIO channel. It holds the output-value and direction registers
// and drives the pins. Assumes W <= 32. A direction bit of 1 means input.
module gpio_channel
    import gpio_dual_pkg::*;
#(
    parameter int               W        = 32,
    parameter logic [REG_W-1:0] VAL_INIT = '0,
    parameter logic [REG_W-1:0] DIR_INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             val_we,
    input  logic             dir_we,
    input  logic [REG_W-1:0] wdata,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe,
    output logic [REG_W-1:0] val_rd,
    output logic [REG_W-1:0] dir_rd
);
    logic [W-1:0] val_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pin_sync;

    // Load the output values and directions from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= VAL_INIT[W-1:0];
            dir_q <= DIR_INIT[W-1:0];
        end else begin
            if (val_we) val_q <= wdata[W-1:0];
            if (dir_we) dir_q <= wdata[W-1:0];
        end
    end

    gpio_sync #(.W(W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_sync)
    );

    assign pin_out = val_q;
    assign pin_oe  = ~dir_q;

    // Zero-extend the synchronised pins and the direction bits to register width
    always_comb begin
        val_rd         = '0;
        val_rd[W-1:0]  = pin_sync;
        dir_rd         = '0;
        dir_rd[W-1:0]  = dir_q;
    end

    p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we |=> pin_oe == ~$past(wdata[W-1:0]));
    p_val_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        val_we |=> pin_out == $past(wdata[W-1:0]));
    p_no_write_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!val_we && !dir_we) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: rtl/gpio_dual_regs.sv
// GPIO register block with one or two channels on a word-addressed port.
// Decodes byte addresses (bits [1:0] ignored) and registers the read data.
// Assumes ADDR_W >= 4. Channel two exists only when DUAL_CHANNEL is 1.
module gpio_dual_regs
    import gpio_dual_pkg::*;
#(
    parameter int               CH1_WIDTH     = 32,
    parameter int               CH2_WIDTH     = 32,
    parameter bit               DUAL_CHANNEL  = 1'b0,
    parameter logic [REG_W-1:0] CH1_VAL_INIT  = '0,
    parameter logic [REG_W-1:0] CH1_DIR_INIT  = '1,
    parameter logic [REG_W-1:0] CH2_VAL_INIT  = '0,
    parameter logic [REG_W-1:0] CH2_DIR_INIT  = '1,
    parameter int               ADDR_W        = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [CH1_WIDTH-1:0] ch1_pin_in,
    output logic [CH1_WIDTH-1:0] ch1_pin_out,
    output logic [CH1_WIDTH-1:0] ch1_pin_oe,
    input  logic [CH2_WIDTH-1:0] ch2_pin_in,
    output logic [CH2_WIDTH-1:0] ch2_pin_out,
    output logic [CH2_WIDTH-1:0] ch2_pin_oe
);
    reg_sel_e         sel;
    logic             in_range;
    logic [REG_W-1:0] val1_rd, dir1_rd, val2_rd, dir2_rd;
    logic             unused_low_addr;

    assign unused_low_addr = ^bus_addr[1:0];

    // Split the address into a register select and a range check
    always_comb begin
        sel      = reg_sel_e'(bus_addr[3:2]);
        in_range = (bus_addr >> 4) == '0;
    end

    gpio_channel #(
        .W       (CH1_WIDTH),
        .VAL_INIT(CH1_VAL_INIT),
        .DIR_INIT(CH1_DIR_INIT)
    ) u_ch1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .val_we (bus_wr && in_range && sel == SEL_VAL1),
        .dir_we (bus_wr && in_range && sel == SEL_DIR1),
        .wdata  (bus_wdata),
        .pin_in (ch1_pin_in),
        .pin_out(ch1_pin_out),
        .pin_oe (ch1_pin_oe),
        .val_rd (val1_rd),
        .dir_rd (dir1_rd)
    );

    generate
        if (DUAL_CHANNEL) begin : g_ch2
            gpio_channel #(
                .W       (CH2_WIDTH),
                .VAL_INIT(CH2_VAL_INIT),
                .DIR_INIT(CH2_DIR_INIT)
            ) u_ch2 (
                .clk    (clk),
                .rst_n  (rst_n),
                .val_we (bus_wr && in_range && sel == SEL_VAL2),
                .dir_we (bus_wr && in_range && sel == SEL_DIR2),
                .wdata  (bus_wdata),
                .pin_in (ch2_pin_in),
                .pin_out(ch2_pin_out),
                .pin_oe (ch2_pin_oe),
                .val_rd (val2_rd),
                .dir_rd (dir2_rd)
            );
        end else begin : g_no_ch2
            logic unused_ch2_in;
            assign unused_ch2_in = ^ch2_pin_in;
            assign ch2_pin_out   = '0;
            assign ch2_pin_oe    = '0;
            assign val2_rd       = '0;
            assign dir2_rd       = '0;

            p_absent_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_rd && in_range && bus_addr[3]) |=> bus_rdata == '0);
        end
    endgenerate

    // Capture the selected register on a read strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (!in_range) begin
                bus_rdata <= '0;
            end else begin
                unique case (sel)
                    SEL_VAL1: bus_rdata <= val1_rd;
                    SEL_DIR1: bus_rdata <= dir1_rd;
                    SEL_VAL2: bus_rdata <= val2_rd;
                    SEL_DIR2: bus_rdata <= dir2_rd;
                endcase
            end
        end
    end

    p_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    p_unused_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_range) |=> bus_rdata == '0);
    p_unused_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !in_range) |=> ($stable(ch1_pin_out) && $stable(ch1_pin_oe)
                                   && $stable(ch2_pin_out) && $stable(ch2_pin_oe)));
endmodule

// File: tb/test_gpio_dual_regs.sv
// Directed bench: one task per scenario, each checking its own results.
module test_gpio_dual_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    // Dual-channel instance: 12-bit channel one, 32-bit channel two
    logic [4:0]  d_addr = '0;
    logic        d_wr = 1'b0, d_rd = 1'b0;
    logic [31:0] d_wdata = '0, d_rdata;
    logic [11:0] d1_in = '0, d1_out, d1_oe;
    logic [31:0] d2_in = '0, d2_out, d2_oe;

    // Single-channel instance: 8-bit channel one, default reset values
    logic [4:0]  s_addr = '0;
    logic        s_wr = 1'b0, s_rd = 1'b0;
    logic [31:0] s_wdata = '0, s_rdata;
    logic [7:0]  s1_in = '0, s1_out, s1_oe;
    logic [31:0] s2_in = '0, s2_out, s2_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    gpio_dual_regs #(
        .CH1_WIDTH(12), .CH2_WIDTH(32), .DUAL_CHANNEL(1'b1),
        .CH1_VAL_INIT(32'h0000_00A5), .CH2_DIR_INIT(32'hFFFF_00FF)
    ) i_gpio_dual_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(d_addr), .bus_wr(d_wr), .bus_rd(d_rd),
        .bus_wdata(d_wdata), .bus_rdata(d_rdata),
        .ch1_pin_in(d1_in), .ch1_pin_out(d1_out), .ch1_pin_oe(d1_oe),
        .ch2_pin_in(d2_in), .ch2_pin_out(d2_out), .ch2_pin_oe(d2_oe)
    );

    gpio_dual_regs #(
        .CH1_WIDTH(8), .DUAL_CHANNEL(1'b0)
    ) i_gpio_dual_regs_single (
        .clk(clk), .rst_n(rst_n), .bus_addr(s_addr), .bus_wr(s_wr), .bus_rd(s_rd),
        .bus_wdata(s_wdata), .bus_rdata(s_rdata),
        .ch1_pin_in(s1_in), .ch1_pin_out(s1_out), .ch1_pin_oe(s1_oe),
        .ch2_pin_in(s2_in), .ch2_pin_out(s2_out), .ch2_pin_oe(s2_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input bit single, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        if (single) begin s_addr = a; s_wdata = d; s_wr = 1'b1; end
        else        begin d_addr = a; d_wdata = d; d_wr = 1'b1; end
        @(negedge clk);
        s_wr = 1'b0; d_wr = 1'b0;
    endtask

    task automatic rd(input bit single, input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        if (single) begin s_addr = a; s_rd = 1'b1; end
        else        begin d_addr = a; d_rd = 1'b1; end
        @(negedge clk);
        s_rd = 1'b0; d_rd = 1'b0;
        d = single ? s_rdata : d_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 rdata after reset", d_rdata, 32'h0);
        check("R1 single out", {24'h0, s1_out}, 32'h0);
        check("R1 single oe", {24'h0, s1_oe}, 32'h0);
        rd(1'b1, 5'h04, v); check("R1 single dir all ones", v, 32'h0000_00FF);
        check("R9 ch1 value init", {20'h0, d1_out}, 32'h0A5);
        check("R9 ch1 oe off", {20'h0, d1_oe}, 32'h0);
        rd(1'b0, 5'h04, v); check("R9 ch1 dir init", v, 32'h0000_0FFF);
        rd(1'b0, 5'h0C, v); check("R9 ch2 dir init", v, 32'hFFFF_00FF);
        check("R9 ch2 oe", d2_oe, 32'h0000_FF00);
    endtask

    task automatic t_direction;
        logic [31:0] v;
        wr(1'b0, 5'h04, 32'h0F0);
        check("R2 oe inverse of dir", {20'h0, d1_oe}, 32'hF0F);
        rd(1'b0, 5'h04, v); check("R2 dir readback", v, 32'h0F0);
    endtask

    task automatic t_value_out;
        wr(1'b0, 5'h00, 32'h3C3);
        check("R3 all values updated", {20'h0, d1_out}, 32'h3C3);
        check("R3 input pins not enabled", {20'h0, d1_oe}, 32'hF0F);
    endtask

    task automatic t_write_timing;
        logic [31:0] v;
        @(negedge clk);
        d_addr = 5'h04; d_wdata = 32'hFFFF_F000; d_wr = 1'b1;
        #1 check("R10 no change before edge", {20'h0, d1_oe}, 32'hF0F);
        @(negedge clk);
        d_wr = 1'b0;
        check("R10 change at edge", {20'h0, d1_oe}, 32'hFFF);
        rd(1'b0, 5'h04, v); check("R10 upper bits dropped", v, 32'h0);
    endtask

    task automatic t_pin_input;
        logic [31:0] v;
        @(negedge clk);
        d1_in = 12'hABC; d2_in = 32'hDEAD_BEEF;
        d_addr = 5'h00; d_rd = 1'b1;
        @(negedge clk);
        d_rd = 1'b0;
        check("R4 same-cycle read returns old level", d_rdata, 32'h0);
        repeat (3) @(negedge clk);
        rd(1'b0, 5'h00, v); check("R4 synchronised ch1, upper bits zero", v, 32'h0000_0ABC);
        rd(1'b0, 5'h08, v); check("R4 synchronised ch2 full width", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_channel2;
        wr(1'b0, 5'h08, 32'h1234_5678);
        check("R5 ch2 values", d2_out, 32'h1234_5678);
        wr(1'b0, 5'h0C, 32'h0);
        check("R5 ch2 all outputs", d2_oe, 32'hFFFF_FFFF);
        check("R5 ch1 value untouched", {20'h0, d1_out}, 32'h3C3);
        check("R5 ch1 oe untouched", {20'h0, d1_oe}, 32'hFFF);
    endtask

    task automatic t_single;
        logic [31:0] v;
        s2_in = 32'hFFFF_FFFF;
        wr(1'b1, 5'h08, 32'h0000_FFFF);
        wr(1'b1, 5'h0C, 32'h0);
        check("R6 ch2 out stays zero", s2_out, 32'h0);
        check("R6 ch2 oe stays zero", s2_oe, 32'h0);
        check("R6 ch1 out untouched", {24'h0, s1_out}, 32'h0);
        check("R6 ch1 oe untouched", {24'h0, s1_oe}, 32'h0);
        rd(1'b1, 5'h04, v); check("R6 ch1 dir untouched", v, 32'h0000_00FF);
        rd(1'b1, 5'h08, v); check("R6 ch2 value reads zero", v, 32'h0);
        rd(1'b1, 5'h04, v);
        rd(1'b1, 5'h0C, v); check("R6 ch2 dir reads zero", v, 32'h0);
    endtask

    task automatic t_unused;
        logic [31:0] v;
        wr(1'b0, 5'h10, 32'hFFFF_FFFF);
        wr(1'b0, 5'h14, 32'h0);
        wr(1'b0, 5'h18, 32'h0);
        wr(1'b0, 5'h1C, 32'h0);
        check("R7 ch1 out untouched", {20'h0, d1_out}, 32'h3C3);
        check("R7 ch1 oe untouched", {20'h0, d1_oe}, 32'hFFF);
        check("R7 ch2 out untouched", d2_out, 32'h1234_5678);
        check("R7 ch2 oe untouched", d2_oe, 32'hFFFF_FFFF);
        rd(1'b0, 5'h00, v);
        rd(1'b0, 5'h18, v); check("R7 unused read zero", v, 32'h0);
    endtask

    task automatic t_read_hold;
        logic [31:0] v;
        rd(1'b0, 5'h0C, v);
        wr(1'b0, 5'h0C, 32'h5555_AAAA);
        repeat (2) @(negedge clk);
        check("R8 rdata holds without strobe", d_rdata, 32'h0);
        rd(1'b0, 5'h0C, v); check("R8 new read one cycle later", v, 32'h5555_AAAA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_value_out();
        t_write_timing();
        t_pin_input();
        t_channel2();
        t_single();
        t_unused();
        t_read_hold();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule